// File: doc/BRIEF.md
# Dual-CPU Interrupt Source Mapper

The block takes 64 level-sensitive interrupt sources and routes them, separately for each of two processors, onto five interrupt output lines per processor. Every processor owns a private register set: a mask vector, one routing code per source, a read-only view of the pending unmasked sources, a mailbox that another agent can set bits in and the owner clears, and a latch for pulsed bridge interrupts with its own clear register.

Software reaches the registers over a simple word-addressed bus. The top address bit selects the processor, and the lower seven bits select the register. Word offsets 0 to 63 hold the routing code of the source with that index. Offset 64 is the mask, 65 the status view, 66 the mailbox (read), 67 mailbox set, 68 mailbox clear, 69 the bridge latch (read) and 70 the bridge clear. A read of any write-only or unused offset returns zero. Source index 26 is taken over by the mailbox: on each processor it is driven by that processor's mailbox, and the external input at that index is ignored.

Top module: `irq_router`

## Requirements
- R1: After reset every mask bit is 1, every routing code is 0, the mailbox and bridge latch registers read 0, and all ten output lines are low.
- R2: A source whose mask bit is 1 on a processor drives no line there and reads as 0 in that processor's status view (offset 65).
- R3: An active source whose mask bit is 0 drives the line given by its routing code, and the routing is independent per processor: output bit `cpu*5 + code` of `irq_line`. The status view shows exactly the active, unmasked sources.
- R4: The routing code of source s sits in bits [2:0] of word offset s. It reads back zero-extended, and codes 0 to 4 select lines 0 to 4.
- R5: Routing codes 5, 6 and 7 drive no line, but the source still shows in the status view.
- R6: Writing to the mailbox set register (offset 67) ORs the data into that processor's mailbox. The mailbox raises source 26 when any of its bits 63:48 is 1. Bits below 48 raise nothing, and the external input 26 is ignored.
- R7: Writing to the mailbox clear register (offset 68) clears each mailbox bit where the data holds a 1 and leaves the rest. Writing all ones empties the mailbox.
- R8: A one-cycle pulse on `bridge_in[s]` latches bit s into the bridge latch of every processor. The latched bit acts as an active source. Writing a 1 to that bit of a processor's bridge clear (offset 70) removes it on that processor only.
- R9: When a bridge pulse and a bridge clear hit the same bit in the same cycle, the bit stays latched.
- R10: A line is the OR of all eligible sources routed to it. It stays high while any one of them remains.
- R11: Read data appears on the cycle after the read strobe and holds until the next read. A source change reaches the lines one clock edge later, and a register write reaches them two clock edges after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Word address: bit 7 processor, bits 6:0 register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| src_in | input | 64 | Level interrupt sources |
| bridge_in | input | 64 | Pulsed bridge interrupts, latched |
| irq_line | output | 10 | Output lines, bit cpu*5+line |

## Verification
A corrupted mask or routing code shows up as a line raised on the wrong processor or the wrong line, or as a status word that disagrees with the lines. Such a fault is visible two edges after the write that set it up. A lost mailbox or bridge bit shows as a line that falls early and as a register readback one cycle after the read strobe. Each check first changes one register, then reads both the lines and the register back, so a wrong state is caught within two cycles of the stimulus that exposes it.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
    localparam int unsigned CODE_W = 3;

    typedef enum logic [3:0] {
        RK_MAP,
        RK_MASK,
        RK_STAT,
        RK_MBOX,
        RK_MBSET,
        RK_MBCLR,
        RK_PEND,
        RK_PCLR,
        RK_NONE
    } reg_kind_e;
endpackage

// File: rtl/irq_router_lines.sv
`timescale 1ns/1ps
module irq_router_lines
    import irq_router_pkg::*;
#(
    parameter int unsigned NSRC  = 64,
    parameter int unsigned NLINE = 5
) (
    input  logic [NSRC-1:0]             elig_i,
    input  logic [NSRC-1:0][CODE_W-1:0] map_i,
    output logic [NLINE-1:0]            line_o
);
    for (genvar l = 0; l < NLINE; l++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < NSRC; s++) begin
                hit = hit | (elig_i[s] && (map_i[s] == CODE_W'(l)));
            end
        end
        assign line_o[l] = hit;
    end
endmodule

// File: rtl/irq_router_bank.sv
`timescale 1ns/1ps
module irq_router_bank
    import irq_router_pkg::*;
#(
    parameter int unsigned NSRC      = 64,
    parameter int unsigned NLINE     = 5,
    parameter int unsigned DW        = 64,
    parameter int unsigned MBOX_SRC  = 26,
    parameter int unsigned MB_RAISE  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  reg_kind_e                kind,
    input  logic [$clog2(NSRC)-1:0]  idx,
    input  logic [DW-1:0]            wdata,
    input  logic [NSRC-1:0]          src_in,
    input  logic [NSRC-1:0]          bridge_in,
    output logic [DW-1:0]            rd_val,
    output logic [NLINE-1:0]         line_o
);
    typedef struct packed {
        logic [NSRC-1:0]             mask;
        logic [NSRC-1:0][CODE_W-1:0] map;
        logic [DW-1:0]               mbox;
        logic [NSRC-1:0]             pend;
        logic [NLINE-1:0]            line;
    } bank_s;

    bank_s bank_d, bank_q;
    logic [NSRC-1:0]  active, elig;
    logic [NLINE-1:0] line_next;

    always_comb begin
        active           = src_in | bank_q.pend;
        active[MBOX_SRC] = |bank_q.mbox[DW-1 -: MB_RAISE];
        elig             = active & ~bank_q.mask;
    end

    irq_router_lines #(.NSRC(NSRC), .NLINE(NLINE)) u_lines (
        .elig_i (elig),
        .map_i  (bank_q.map),
        .line_o (line_next)
    );

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (kind)
                RK_MAP:   bank_d.map[idx] = wdata[CODE_W-1:0];
                RK_MASK:  bank_d.mask     = wdata[NSRC-1:0];
                RK_MBSET: bank_d.mbox     = bank_q.mbox | wdata;
                RK_MBCLR: bank_d.mbox     = bank_q.mbox & ~wdata;
                RK_PCLR:  bank_d.pend     = bank_q.pend & ~wdata[NSRC-1:0];
                default:  ;
            endcase
        end
        bank_d.pend = bank_d.pend | bridge_in;
        bank_d.line = line_next;
    end

    always_comb begin
        case (kind)
            RK_MAP:  rd_val = DW'(bank_q.map[idx]);
            RK_MASK: rd_val = DW'(bank_q.mask);
            RK_STAT: rd_val = DW'(elig);
            RK_MBOX: rd_val = bank_q.mbox;
            RK_PEND: rd_val = DW'(bank_q.pend);
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q      <= '0;
            bank_q.mask <= '1;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign line_o = bank_q.line;

    assert_masked_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&bank_q.mask) |=> (bank_q.line == '0));
    assert_mbox_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == RK_MBSET) |=> ((bank_q.mbox & $past(wdata)) == $past(wdata)));
    assert_mbox_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == RK_MBCLR) |=> ((bank_q.mbox & $past(wdata)) == '0));
    assert_bridge_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|bridge_in) |=> ((bank_q.pend & $past(bridge_in)) == $past(bridge_in)));
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
    import irq_router_pkg::*;
#(
    parameter int unsigned NSRC     = 64,
    parameter int unsigned NCPU     = 2,
    parameter int unsigned NLINE    = 5,
    parameter int unsigned DW       = 64,
    parameter int unsigned MBOX_SRC = 26,
    parameter int unsigned MB_RAISE = 16,
    localparam int unsigned OFS_W   = $clog2(NSRC + 8),
    localparam int unsigned CPU_W   = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int unsigned ADDR_W  = CPU_W + OFS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    input  logic [NSRC-1:0]        src_in,
    input  logic [NSRC-1:0]        bridge_in,
    output logic [NCPU*NLINE-1:0]  irq_line
);
    localparam int unsigned IDX_W = $clog2(NSRC);
    localparam logic [OFS_W-1:0] OFS_MASK  = OFS_W'(NSRC);
    localparam logic [OFS_W-1:0] OFS_STAT  = OFS_W'(NSRC + 1);
    localparam logic [OFS_W-1:0] OFS_MBOX  = OFS_W'(NSRC + 2);
    localparam logic [OFS_W-1:0] OFS_MBSET = OFS_W'(NSRC + 3);
    localparam logic [OFS_W-1:0] OFS_MBCLR = OFS_W'(NSRC + 4);
    localparam logic [OFS_W-1:0] OFS_PEND  = OFS_W'(NSRC + 5);
    localparam logic [OFS_W-1:0] OFS_PCLR  = OFS_W'(NSRC + 6);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } top_s;

    top_s top_d, top_q;
    logic [CPU_W-1:0] cpu_sel;
    logic [OFS_W-1:0] ofs;
    reg_kind_e        kind;
    logic [DW-1:0]    bank_rd [NCPU];

    assign cpu_sel = bus_addr[ADDR_W-1 -: CPU_W];
    assign ofs     = bus_addr[OFS_W-1:0];

    always_comb begin
        if (ofs < OFS_MASK) begin
            kind = RK_MAP;
        end else begin
            case (ofs)
                OFS_MASK:  kind = RK_MASK;
                OFS_STAT:  kind = RK_STAT;
                OFS_MBOX:  kind = RK_MBOX;
                OFS_MBSET: kind = RK_MBSET;
                OFS_MBCLR: kind = RK_MBCLR;
                OFS_PEND:  kind = RK_PEND;
                OFS_PCLR:  kind = RK_PCLR;
                default:   kind = RK_NONE;
            endcase
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        irq_router_bank #(
            .NSRC(NSRC), .NLINE(NLINE), .DW(DW),
            .MBOX_SRC(MBOX_SRC), .MB_RAISE(MB_RAISE)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_wr && (cpu_sel == CPU_W'(c))),
            .kind      (kind),
            .idx       (ofs[IDX_W-1:0]),
            .wdata     (bus_wdata),
            .src_in    (src_in),
            .bridge_in (bridge_in),
            .rd_val    (bank_rd[c]),
            .line_o    (irq_line[c*NLINE +: NLINE])
        );
    end

    always_comb begin
        top_d = top_q;
        if (bus_rd) begin
            top_d.rdata = bank_rd[cpu_sel];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign bus_rdata = top_q.rdata;

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic [63:0] bridge_in = '0;
    logic [9:0]  irq_line;

    int checks = 0;
    int fails  = 0;
    logic [63:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    localparam logic [6:0] O_MASK = 7'd64, O_STAT = 7'd65, O_MBOX = 7'd66,
                           O_MBSET = 7'd67, O_MBCLR = 7'd68, O_PEND = 7'd69,
                           O_PCLR = 7'd70;

    always #2.5 clk = ~clk;

    irq_router uut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .bridge_in(bridge_in), .irq_line(irq_line)
    );

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic cpu, input logic [6:0] ofs, input logic [63:0] data);
        bus_wr = 1'b1; bus_addr = {cpu, ofs}; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic cpu, input logic [6:0] ofs, input logic [63:0] exp,
                      input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = {cpu, ofs};
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_lines(input logic [9:0] exp, input string tag);
        checks++;
        if (irq_line !== exp) begin
            fails++;
            $display("FAIL %s lines actual=%h expected=%h", tag, irq_line, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk_lines(10'h000, "R1");
        rd(1'b0, O_MASK, '1, "R1 mask");
        rd(1'b1, 7'd9, 64'd0, "R1 map");
        rd(1'b0, O_MBOX, 64'd0, "R1 mbox");
        rd(1'b1, O_PEND, 64'd0, "R1 pend");

        src_in[3] = 1'b1; step();
        chk_lines(10'h000, "R2");
        rd(1'b0, O_STAT, 64'd0, "R2 status");

        wr(1'b0, O_MASK, ~64'h8); step();
        chk_lines(10'h001, "R3 default code");
        rd(1'b0, O_STAT, 64'h8, "R3 status");
        rd(1'b1, O_STAT, 64'h0, "R3 other cpu");

        wr(1'b0, 7'd3, 64'd4); step();
        chk_lines(10'h010, "R4 code4");
        rd(1'b0, 7'd3, 64'd4, "R4 readback");

        wr(1'b0, 7'd3, 64'd6); step();
        chk_lines(10'h000, "R5 code6");
        rd(1'b0, O_STAT, 64'h8, "R5 status");
        wr(1'b0, 7'd3, 64'd7); step();
        chk_lines(10'h000, "R5 code7");

        // R10: two sources on line 1 of cpu0
        wr(1'b0, 7'd3, 64'd1);
        wr(1'b0, 7'd5, 64'd1);
        wr(1'b0, O_MASK, ~64'h28);
        src_in[5] = 1'b1; step();
        chk_lines(10'h002, "R10 both");
        src_in[3] = 1'b0; step();
        chk_lines(10'h002, "R10 one left");
        src_in[5] = 1'b0; step();
        chk_lines(10'h000, "R10 none");

        // R3: per-cpu routing of the same source
        wr(1'b1, O_MASK, ~64'h8);
        wr(1'b1, 7'd3, 64'd2);
        src_in[3] = 1'b1; step();
        chk_lines(10'h082, "R3 both cpus");

        // R11: source and write latency
        src_in[3] = 1'b0; #1;
        chk_lines(10'h082, "R11 before edge");
        step();
        chk_lines(10'h000, "R11 one edge");
        src_in[3] = 1'b1; step();
        wr(1'b0, O_MASK, '1);
        chk_lines(10'h082, "R11 write +1");
        step();
        chk_lines(10'h080, "R11 write +2");
        wr(1'b1, O_MASK, '1);
        src_in[3] = 1'b0; step();
        rd(1'b1, 7'd3, 64'd2, "R11 read");

        // mailbox
        wr(1'b1, O_MASK, ~(64'd1 << 26));
        src_in[26] = 1'b1; step();
        chk_lines(10'h000, "R6 external ignored");
        wr(1'b1, O_MBSET, 64'd1 << 10); step();
        chk_lines(10'h000, "R6 low bit");
        rd(1'b1, O_MBOX, 64'd1 << 10, "R6 set");
        wr(1'b1, O_MBSET, 64'd1 << 50); step();
        chk_lines(10'h020, "R6 high bit");
        rd(1'b1, O_MBOX, (64'd1 << 50) | (64'd1 << 10), "R6 or");
        rd(1'b0, O_MBOX, 64'd0, "R6 other cpu");
        wr(1'b1, O_MBCLR, 64'd1 << 50); step();
        chk_lines(10'h000, "R7 clear");
        rd(1'b1, O_MBOX, 64'd1 << 10, "R7 others kept");
        wr(1'b1, O_MBCLR, '1);
        rd(1'b1, O_MBOX, 64'd0, "R7 all ones");
        src_in[26] = 1'b0;

        // bridge latch
        wr(1'b0, O_MASK, ~64'h80);
        bridge_in[7] = 1'b1; step();
        bridge_in[7] = 1'b0; step();
        chk_lines(10'h001, "R8 latched");
        rd(1'b1, O_PEND, 64'h80, "R8 all cpus");
        wr(1'b0, O_PCLR, 64'h80); step();
        chk_lines(10'h000, "R8 cleared");
        rd(1'b0, O_PEND, 64'h0, "R8 cpu0");
        rd(1'b1, O_PEND, 64'h80, "R8 cpu1 kept");

        bridge_in[7] = 1'b1;
        wr(1'b1, O_PCLR, 64'h80);
        bridge_in[7] = 1'b0;
        rd(1'b1, O_PEND, 64'h80, "R9 set wins");
        wr(1'b1, O_PCLR, 64'h80);
        rd(1'b1, O_PEND, 64'h0, "R9 later clear");

        step(); step();
        finish_run();
    end
endmodule